// File: doc/BRIEF.md
# Byte Parity Protected Memory

This block wraps a small byte-wide storage array so that every location holds nine bits: the data byte plus one check bit. The check bit is generated in hardware when the byte is written. When the byte is read, the check bit is computed again from the returned byte and compared with the stored one. A mismatch is reported with the read data, and it also sets a sticky error flag that records the address of the failing read.

A host issues one request per cycle: a write or a read, chosen by the write-enable input. Read data comes back one cycle later, qualified by a valid strobe. A fault-injection input XORs a 9-bit mask into any stored word. This can corrupt the data or the check bit directly. It shows that a single flipped bit is caught and that two flipped bits pass unnoticed. The design detects errors only and does not correct them.

Top module: `parity_mem_wrap`

## Requirements
- R1: A write stores the byte in bits 7:0 and a check bit in bit 8 of the word. The check bit is 1 when the byte has an even number of ones and 0 when the count is odd (0x55 gives 1, 0x5D gives 0). A later read returns the written byte unchanged.
- R2: `rvalid_o` is high in exactly the cycle after a read request (`req_i`=1, `we_i`=0). It is low in every other cycle.
- R3: `rerr_o` is high with `rvalid_o` when the check bit recomputed from the returned byte differs from the stored check bit. It is low otherwise.
- R4: When `inj_en_i`=1, the word at `inj_addr_i` is XORed with `inj_mask_i` at the clock edge. Mask bit 8 hits the check bit and bits 7:0 hit the data. A single-bit flip makes the next read of that word report `rerr_o`.
- R5: Flipping any two bits of a stored word raises no error. The read returns the corrupted byte with `rerr_o`=0.
- R6: `err_o` rises in the same cycle as the first `rerr_o` and stays high until `err_clr_i` is applied. A read error that coincides with a clear keeps `err_o` high.
- R7: `err_addr_o` holds the address of the first failing read since the last clear. Later errors do not change it while `err_o` is high. An error that coincides with a clear loads the new address.
- R8: Reset drives `rvalid_o`, `rerr_o`, `err_o`, `rdata_o` and `err_addr_o` to 0 and clears every stored word to nine zero bits. A read of a location never written therefore returns 0x00 with `rerr_o`=1.
- R9: A write and an injection to the same address in the same cycle store the written word, and the mask is discarded. A read issued in the same cycle as an injection to its address returns the contents from before the injection.
- R10: `rdata_o` is 0x00 in every cycle in which `rvalid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid |
| rerr_o | output | 1 | Check-bit mismatch on this read |
| err_o | output | 1 | Sticky error flag |
| err_clr_i | input | 1 | Clears the sticky error flag |
| err_addr_o | output | ADDR_W | Address of the first failing read |
| inj_en_i | input | 1 | Apply the fault mask this cycle |
| inj_addr_i | input | ADDR_W | Word to corrupt |
| inj_mask_i | input | 9 | XOR mask, bit 8 = check bit |

## Verification
The bench targets the following corner cases:
- A read of a never-written word after reset. This exposes the check-bit polarity: a design that stored an odd-count check bit would miss the error there, or would flag correctly written bytes.
- Double flips, including one that combines a data bit with the check bit. A design that compared anything other than a single recomputed bit would report these.
- A clear that lands together with a new error, and a second error while the flag is already set. These catch a design where the clear wins or where the recorded address is overwritten.
- A write and an injection to one address in the same cycle, and a read beside an injection. These catch a design where the mask leaks into fresh data or the read sees post-edge contents.

// File: rtl/parity_mem_pkg.sv
package parity_mem_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = BYTE_W + 1;

  typedef struct packed {
    logic              chk;
    logic [BYTE_W-1:0] data;
  } word_t;
endpackage

// File: rtl/pmw_chk_gen.sv
// Check bit: 1 for an even count of ones.
module pmw_chk_gen
  import parity_mem_pkg::*;
(
  input  logic [BYTE_W-1:0] data_i,
  output logic              chk_o
);
  logic [BYTE_W:0] acc;
  assign acc[0] = 1'b1;
  for (genvar i = 0; i < BYTE_W; i++) begin : g_xor
    assign acc[i+1] = acc[i] ^ data_i[i];
  end
  assign chk_o = acc[BYTE_W];
endmodule

// File: rtl/pmw_store.sv
module pmw_store
  import parity_mem_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  word_t             wr_word_i,
  input  logic              inj_en_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  logic [WORD_W-1:0] inj_mask_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output word_t             rd_word_o
);
  word_t mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic hit_wr, hit_inj;
    assign hit_wr  = wr_en_i  && (wr_addr_i  == ADDR_W'(i));
    assign hit_inj = inj_en_i && (inj_addr_i == ADDR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      mem_q[i] <= '0;
      else if (hit_wr)  mem_q[i] <= wr_word_i;  // write beats injection
      else if (hit_inj) mem_q[i] <= mem_q[i] ^ inj_mask_i;
    end
  end

  assign rd_word_o = mem_q[rd_addr_i];
endmodule

// File: rtl/pmw_read_stage.sv
module pmw_read_stage
  import parity_mem_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_fire_i,
  input  word_t             rd_word_i,
  output logic              mismatch_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              rerr_o
);
  logic chk_calc;

  pmw_chk_gen u_chk (.data_i(rd_word_i.data), .chk_o(chk_calc));

  assign mismatch_o = rd_fire_i && (chk_calc != rd_word_i.chk);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rerr_o   <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_fire_i;
      rerr_o   <= mismatch_o;
      rdata_o  <= rd_fire_i ? rd_word_i.data : '0;
    end
  end
endmodule

// File: rtl/pmw_err_log.sv
module pmw_err_log #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] hit_addr_i,
  input  logic              clr_i,
  output logic              err_o,
  output logic [ADDR_W-1:0] err_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o      <= 1'b0;
      err_addr_o <= '0;
    end else if (hit_i) begin
      err_o <= 1'b1;
      if (!err_o || clr_i) err_addr_o <= hit_addr_i;
    end else if (clr_i) begin
      err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/parity_mem_wrap.sv
module parity_mem_wrap
  import parity_mem_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o,
  output logic              rerr_o,
  output logic              err_o,
  input  logic              err_clr_i,
  output logic [ADDR_W-1:0] err_addr_o,
  input  logic              inj_en_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  logic [8:0]        inj_mask_i
);
  logic  wr_fire, rd_fire, wr_chk, mismatch;
  word_t wr_word, rd_word;

  assign wr_fire = req_i && we_i;
  assign rd_fire = req_i && !we_i;

  pmw_chk_gen u_gen (.data_i(wdata_i), .chk_o(wr_chk));

  assign wr_word = '{chk: wr_chk, data: wdata_i};

  pmw_store #(.ADDR_W(ADDR_W)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_fire), .wr_addr_i(addr_i), .wr_word_i(wr_word),
    .inj_en_i, .inj_addr_i, .inj_mask_i,
    .rd_addr_i(addr_i), .rd_word_o(rd_word)
  );

  pmw_read_stage u_rd (
    .clk_i, .rst_ni,
    .rd_fire_i(rd_fire), .rd_word_i(rd_word),
    .mismatch_o(mismatch), .rdata_o, .rvalid_o, .rerr_o
  );

  pmw_err_log #(.ADDR_W(ADDR_W)) u_log (
    .clk_i, .rst_ni,
    .hit_i(mismatch), .hit_addr_i(addr_i), .clr_i(err_clr_i),
    .err_o, .err_addr_o
  );
endmodule

// File: rtl/parity_mem_wrap_chk.sv
module parity_mem_wrap_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [7:0]        rdata_o,
  input logic              rvalid_o,
  input logic              rerr_o,
  input logic              err_o,
  input logic              err_clr_i,
  input logic [ADDR_W-1:0] err_addr_o
);
  assert_rvalid_after_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  assert_rvalid_only_after_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
  assert_rerr_qualified_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerr_o |-> rvalid_o);
  assert_rerr_sets_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerr_o |-> err_o);
  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);
  assert_clear_works_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !(req_i && !we_i)) |=> !err_o);
  assert_addr_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> $stable(err_addr_o));
  assert_idle_data_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == 8'h00));
endmodule

bind parity_mem_wrap parity_mem_wrap_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i, .rst_ni, .req_i, .we_i, .rdata_o, .rvalid_o, .rerr_o,
  .err_o, .err_clr_i, .err_addr_o
);

// File: tb/parity_mem_wrap_tb_top.sv
module parity_mem_wrap_tb_top;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0, err_clr_i = 1'b0, inj_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0, inj_addr_i = '0;
  logic [7:0]    wdata_i = '0;
  logic [8:0]    inj_mask_i = '0;
  logic [7:0]    rdata_o;
  logic          rvalid_o, rerr_o, err_o;
  logic [AW-1:0] err_addr_o;

  always #5 clk_i = ~clk_i;

  parity_mem_wrap #(.ADDR_W(AW)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [8:0]    m_mem [DEPTH];
  logic          e_rvalid = 0, e_rerr = 0, e_err = 0;
  logic [7:0]    e_rdata = 0;
  logic [AW-1:0] e_eaddr = 0;

  function automatic logic even_bit(input logic [7:0] b);
    int c = 0;
    for (int i = 0; i < 8; i++) if (b[i]) c++;
    return (c % 2) == 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 rvalid", int'(rvalid_o), int'(e_rvalid));
    if (e_rvalid) check("R1 rdata", int'(rdata_o), int'(e_rdata));
    else          check("R10 rdata idle", int'(rdata_o), 0);
    check("R3 rerr", int'(rerr_o), int'(e_rerr));
    check("R6 err", int'(err_o), int'(e_err));
    check("R7 err_addr", int'(err_addr_o), int'(e_eaddr));
  endtask

  task automatic step(input logic req, input logic we, input int a, input int wd,
                      input logic clr, input logic inj, input int ia, input int m);
    logic rd, mism;
    req_i = req; we_i = we; addr_i = AW'(a); wdata_i = 8'(wd);
    err_clr_i = clr; inj_en_i = inj; inj_addr_i = AW'(ia); inj_mask_i = 9'(m);
    rd   = req && !we;
    mism = rd && (m_mem[a][8] != even_bit(m_mem[a][7:0]));
    e_rvalid = rd;
    e_rdata  = rd ? m_mem[a][7:0] : 8'h00;
    e_rerr   = mism;
    if (mism) begin
      if (!e_err || clr) e_eaddr = AW'(a);
      e_err = 1;
    end else if (clr) e_err = 0;
    if (inj && !(req && we && ia == a)) m_mem[ia] = m_mem[ia] ^ 9'(m);
    if (req && we) m_mem[a] = {even_bit(8'(wd)), 8'(wd)};
    @(posedge clk_i);
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic wr(input int a, input int d);    step(1,1,a,d,0,0,0,0); endtask
  task automatic rd(input int a);                 step(1,0,a,0,0,0,0,0); endtask
  task automatic inj(input int a, input int m);   step(0,0,0,0,0,1,a,m); endtask
  task automatic clr();                           step(0,0,0,0,1,0,0,0); endtask
  task automatic idle();                          step(0,0,0,0,0,0,0,0); endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 9'h000;
    repeat (3) @(negedge clk_i);
    compare_all();              // R8 reset state
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_all();
    // R8: unwritten location reads 0 with an error (zero ones -> check bit 1 expected)
    rd(3);
    check("R8 unwritten rerr", int'(rerr_o), 1);
    idle();
    clr();
    // R1: polarity examples and round trips
    wr(1, 'h55); wr(2, 'h5D); wr(4, 'h00); wr(5, 'hFF);
    rd(1); rd(2); rd(4); rd(5);
    check("R1 no error on clean data", int'(err_o), 0);
    // R4: single flips on data and check bit
    inj(1, 'h001); rd(1);
    check("R4 data flip flagged", int'(rerr_o), 1);
    inj(2, 'h100); rd(2);
    check("R7 first address kept", int'(err_addr_o), 1);
    // R6/R7: clear coinciding with new error
    step(1,0,2,0,1,0,0,0);
    check("R6 set beats clear", int'(err_o), 1);
    check("R7 address reloaded", int'(err_addr_o), 2);
    clr(); idle();
    // R5: double flips pass unnoticed
    inj(4, 'h003); rd(4);
    check("R5 double data flip", int'(rerr_o), 0);
    inj(5, 'h180); rd(5);
    check("R5 data+check flip", int'(rerr_o), 0);
    // R9: write wins over injection; read beside injection sees old word
    step(1,1,6,'h11,0,1,6,'h001);
    rd(6);
    step(1,0,6,0,0,1,6,'h002);
    check("R9 read before inject", int'(rdata_o), 'h11);
    rd(6);
    check("R9 injected afterwards", int'(rerr_o), 1);
    clr();
    // sweep all locations
    for (int i = 0; i < DEPTH; i++) wr(i, (i * 37 + 11) & 'hFF);
    for (int i = 0; i < DEPTH; i++) rd(i);
    check("R1 sweep clean", int'(err_o), 0);
    idle();
    done = 1;
    summary();
    $finish;
  end
endmodule